// File: doc/BRIEF.md
# Triangular PWM Duty Ramp Sequencer

This block drives the compare settings of an external PWM timer so that its duty sweeps down and back up in steps of one tenth of the period. Each pulse on the tick input, which comes from a slow interval timer, moves the sequencer one step and produces one register write for the PWM timer. The duty falls from 90 % to 0 % and then rises back to 90 %, and the pattern repeats without end. Normally the new compare value goes only to the timer's buffer register, which the timer copies into its active compare register at the next compare match.

A duty of 0 % is made by a compare value that the counter never reaches. With no match, the buffer copy never happens, so the sequencer cannot leave 0 % through the buffer alone. When it leaves 0 %, it therefore writes the 10 % value to the active compare register and to the buffer register in the same cycle.

The step index runs from 0 to 2*STEPS-2. Indices 0 to STEPS-1 describe the falling half. Index STEPS starts the rising half. The last index closes the loop and wraps to 0.

Top module: `ramp_duty_seq`

## Requirements
- R1: While reset is asserted and until the first tick after reset, buf_we_o and cmp_we_o are 0 and phase_o is 0.
- R2: A cycle with tick_i low causes no write strobe in the next cycle and leaves phase_o unchanged.
- R3: A tick sampled at a rising edge raises buf_we_o for exactly the next cycle, and the written value belongs to the phase that phase_o showed when the tick was sampled.
- R4: phase_o advances by one on every tick and wraps from 2*STEPS-2 (18) back to 0.
- R5: At phases 0 to 8 the buffer value is the one for duty (90 - 10*phase) %. The value for duty d % is (100-d)*PERIOD/100 - 1, so 319 at 90 % and 2879 at 10 %, with PERIOD = 3200.
- R6: At phase 9 the buffer value is FFFFh, which encodes 0 % duty.
- R7: At phase 10, cmp_we_o and buf_we_o are both high in the same cycle, and both carry 2879 (10 %).
- R8: At phase 18 the buffer value is 319 (90 %) and phase_o returns to 0.
- R9: cmp_we_o is high only for a tick taken at phase 10.
- R10: At phases 11 to 17 the buffer value is the one for duty (10*(phase-9)) %, given by the formula in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Single-cycle step request from the interval timer |
| buf_we_o | output | 1 | Write strobe for the PWM buffer register |
| buf_data_o | output | 16 | Value written to the buffer register |
| cmp_we_o | output | 1 | Write strobe for the active compare register |
| cmp_data_o | output | 16 | Value written to the active compare register |
| phase_o | output | 5 | Current step index |

## Verification
The bench steps through several complete triangles. Some ticks are back to back and others are spaced apart, and a reset arrives in the middle of a sweep. Three errors are targeted:
- Writing the 0 % code at the wrong phase would show up as a wrong value at phase 9.
- Leaving 0 % through the buffer alone would show up as a missing compare strobe at phase 10.
- Mishandling the wrap from 18 to 0 would show up as a wrong phase value after the wrap, or as a top value other than 319.

Strobes that last more than one cycle, or that appear without a tick, break the cycle-by-cycle comparison against the reference model.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

  // Compare value for a duty of `level` tenths of the period; level 0 maps to
  // the all-ones code that the counter never reaches.
  function automatic logic [15:0] level_to_cmp(input int unsigned level,
                                               input int unsigned steps,
                                               input int unsigned period);
    int unsigned slice;
    slice = period / steps;
    if (level == 0) return 16'hFFFF;
    return 16'(period - level * slice - 1);
  endfunction

endpackage

// File: rtl/ramp_index.sv
module ramp_index #(
  parameter int unsigned STEPS = 10,
  parameter int unsigned IW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [IW-1:0] idx
);
  localparam int unsigned LAST = 2 * STEPS - 2;

  logic [IW-1:0] idx_nxt;

  always_comb begin
    idx_nxt = idx;
    if (tick) begin
      if (idx == IW'(LAST)) idx_nxt = '0;
      else                  idx_nxt = idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else        idx <= idx_nxt;
  end

  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(LAST));

  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> idx == (($past(idx) == IW'(LAST)) ? '0 : $past(idx) + 1'b1));

  p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(idx));

endmodule

// File: rtl/ramp_lookup.sv
module ramp_lookup
  import ramp_pkg::*;
#(
  parameter int unsigned STEPS  = 10,
  parameter int unsigned PERIOD = 3200,
  parameter int unsigned IW     = 5
) (
  input  logic [IW-1:0] idx,
  output logic [15:0]   value,
  output logic          direct
);
  localparam int unsigned FLOOR = STEPS - 1;

  int unsigned level;

  always_comb begin
    if (int'(idx) <= int'(FLOOR)) level = FLOOR - int'(idx);
    else                          level = int'(idx) - FLOOR;
    value  = level_to_cmp(level, STEPS, PERIOD);
    direct = (idx == IW'(STEPS));
  end

endmodule

// File: rtl/ramp_duty_seq.sv
module ramp_duty_seq #(
  parameter int unsigned STEPS  = 10,
  parameter int unsigned PERIOD = 3200,
  parameter int unsigned IW     = $clog2(2 * STEPS - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  output logic          buf_we_o,
  output logic [15:0]   buf_data_o,
  output logic          cmp_we_o,
  output logic [15:0]   cmp_data_o,
  output logic [IW-1:0] phase_o
);
  logic [1:0]  rst_pipe;
  logic        rst_sync_n;
  logic [15:0] lk_value;
  logic        lk_direct;

  logic        buf_we_nxt, cmp_we_nxt;
  logic [15:0] buf_data_nxt, cmp_data_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  ramp_index #(.STEPS(STEPS), .IW(IW)) u_index (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick_i),
    .idx   (phase_o)
  );

  ramp_lookup #(.STEPS(STEPS), .PERIOD(PERIOD), .IW(IW)) u_lookup (
    .idx    (phase_o),
    .value  (lk_value),
    .direct (lk_direct)
  );

  always_comb begin
    buf_we_nxt   = tick_i;
    cmp_we_nxt   = tick_i & lk_direct;
    buf_data_nxt = buf_data_o;
    cmp_data_nxt = cmp_data_o;
    if (tick_i)              buf_data_nxt = lk_value;
    if (tick_i && lk_direct) cmp_data_nxt = lk_value;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      buf_we_o   <= 1'b0;
      cmp_we_o   <= 1'b0;
      buf_data_o <= '0;
      cmp_data_o <= '0;
    end else begin
      buf_we_o   <= buf_we_nxt;
      cmp_we_o   <= cmp_we_nxt;
      buf_data_o <= buf_data_nxt;
      cmp_data_o <= cmp_data_nxt;
    end
  end

  p_quiet_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tick_i |=> !buf_we_o && !cmp_we_o);

  p_strobe_follows_tick_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tick_i |=> buf_we_o);

  p_cmp_pairs_buf_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmp_we_o |-> buf_we_o && (cmp_data_o == buf_data_o));

  p_cmp_only_leaving_floor_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmp_we_o |-> phase_o == IW'(STEPS + 1));

endmodule

// File: tb/tb_ramp_duty_seq.sv
module tb_ramp_duty_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        buf_we_o, cmp_we_o;
  logic [15:0] buf_data_o, cmp_data_o;
  logic [4:0]  phase_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference model state
  int  m_phase = 0;
  bit  m_bwe = 0, m_cwe = 0;
  int  m_bval = 0, m_cval = 0;
  int  m_tag_phase = -1;   // phase at which the last tick was taken
  bit  m_in_reset = 1;

  always #2.5 clk = ~clk;

  ramp_duty_seq dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .buf_we_o(buf_we_o), .buf_data_o(buf_data_o),
    .cmp_we_o(cmp_we_o), .cmp_data_o(cmp_data_o),
    .phase_o(phase_o)
  );

  function automatic int duty_at(int ph);
    if (ph <= 9) return 90 - 10 * ph;
    return 10 * (ph - 9);
  endfunction

  function automatic int cmp_of(int duty);
    if (duty == 0) return 65535;
    return (100 - duty) * 32 - 1;
  endfunction

  function automatic string tag_of(int ph);
    if (ph < 0)   return "R1";
    if (ph == 9)  return "R6";
    if (ph == 10) return "R7";
    if (ph == 18) return "R8";
    if (ph < 9)   return "R5";
    return "R10";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0; m_bwe <= 0; m_cwe <= 0; m_tag_phase <= -1; m_in_reset <= 1;
    end else begin
      m_in_reset <= 0;
      m_bwe <= tick_i;
      m_cwe <= tick_i && (m_phase == 10);
      if (tick_i) begin
        m_bval <= cmp_of(duty_at(m_phase));
        if (m_phase == 10) m_cval <= cmp_of(duty_at(m_phase));
        m_tag_phase <= m_phase;
        m_phase <= (m_phase == 18) ? 0 : m_phase + 1;
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(int'(phase_o) == m_phase, "R4", "phase", phase_o, m_phase);
      check(buf_we_o == m_bwe, m_bwe ? "R3" : (m_in_reset ? "R1" : "R2"),
            "buf_we", buf_we_o, m_bwe);
      check(cmp_we_o == m_cwe, m_cwe ? "R7" : "R9", "cmp_we", cmp_we_o, m_cwe);
      if (m_bwe)
        check(int'(buf_data_o) == m_bval, tag_of(m_tag_phase), "buf_data",
              buf_data_o, m_bval);
      if (m_cwe)
        check(int'(cmp_data_o) == m_cval, "R7", "cmp_data", cmp_data_o, m_cval);
    end
  end

  task automatic pulse(int gap);
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);   // R1: idle after reset, no writes
    for (int i = 0; i < 25; i++) pulse(i % 4);
    // back-to-back ticks across the floor and the wrap
    @(negedge clk); tick_i = 1'b1;
    repeat (30) @(negedge clk);
    tick_i = 1'b0;
    repeat (3) @(negedge clk);
    // reset mid-sweep
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 40; i++) pulse((i * 7) % 5);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule